// File: doc/BRIEF.md
# Vectored Level-Sensitive Interrupt Controller

This block collects a parameterised number of level-sensitive interrupt lines (96 by default, up to 128) and presents one interrupt request to a processor. The lines are organised in banks of 32. Each bank has a mask register, two write-one aliases that set or clear mask bits, and a read-only view of the lines that are both asserted and unmasked. Every line also has its own 8-bit priority register. A global threshold can hold back lines whose priority is not good enough.

When the request output is low and at least one line qualifies, the controller picks a winner and latches its number into an active-number register. It raises the request in the same clock edge. The number stays frozen until software writes an acknowledge. The next selection is made one cycle after that write. A self-clearing soft reset returns every register to its default over a fixed number of cycles, and a status flag shows when the reset has finished. All accesses go through a simple single-cycle register port. Reads are combinational and writes take effect at the clock edge.

Top module: `intc_vec_top`

## Requirements
- R1: After reset the revision register (0x000) reads 0x21 (major in bits [7:4], minor in bits [3:0]). Every mask register reads all ones, every pending register reads 0, the active register (0x040) reads 0, the threshold reads 0xFF and irq_o is low.
- R2: Writing to the unmask alias of bank k (0x088+0x20*k) clears the mask bits at the positions written as 1. Bits written as 0 keep their value.
- R3: Writing to the mask alias of bank k (0x08C+0x20*k) sets the mask bits at the positions written as 1. Other bits keep their value.
- R4: The pending register of bank k (0x098+0x20*k) reads the live line levels ANDed with the inverted mask. The mask register itself (0x084+0x20*k) can be read and written directly.
- R5: Among qualifying lines, the winner is the one whose priority field holds the smallest value. When values are equal, the lower line number wins.
- R6: A line qualifies only if its priority value is strictly below the threshold (0x068, bits [7:0]). A threshold of 0xFF turns the check off. With no qualifying line, irq_o stays low.
- R7: irq_o rises on the first clock edge at which a line qualifies while irq_o is low. From that edge the active register reports the winner's number in bits [6:0]. That number and irq_o hold even if the line drops or a better line arrives.
- R8: Writing 1 to bit 0 of the control register (0x048) drops irq_o and clears the active register at the next edge. Selection resumes one edge later. Writing 0 there has no effect.
- R9: The priority register of line i (0x100+4*i) stores bits [7:0] and reads upper bits as zero. The threshold stores bits [7:0], the idle register (0x050) stores bits [1:0], and the autoidle bit is bit 0 of the configuration register (0x010). All of them read back what was written.
- R10: Writing 1 to bit 1 of 0x010 starts a soft reset. For 4 cycles, bit 1 of 0x010 reads 1, bit 0 of the status register (0x014) reads 0, and bus writes are ignored. Afterwards every register is at its default, irq_o is low and the status bit reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_SRC | Level-sensitive interrupt lines |
| bus_sel | input | 1 | Register access valid |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
Two events can land on the same clock edge: the acknowledge write and the arrival of a new, better line. The bench raises a fresh highest-priority line in the same cycle as the acknowledge write. It then expects the active register to read 0 on the next cycle and the new line's number on the cycle after that, so the old number is never replaced without a release. Before this, the bench also holds an active number while a better line becomes pending, and it confirms the number does not move.

// File: rtl/intc_pkg.sv
package intc_pkg;

  localparam int OFF_REV     = 'h000;
  localparam int OFF_SYSCFG  = 'h010;
  localparam int OFF_STATUS  = 'h014;
  localparam int OFF_ACTIVE  = 'h040;
  localparam int OFF_CTRL    = 'h048;
  localparam int OFF_IDLE    = 'h050;
  localparam int OFF_THRESH  = 'h068;
  localparam int OFF_BANK0   = 'h080;
  localparam int BANK_STRIDE = 'h20;
  localparam int OFF_PRIO    = 'h100;

  localparam logic [4:0] SUB_MASK = 5'h04;
  localparam logic [4:0] SUB_CLR  = 5'h08;
  localparam logic [4:0] SUB_SET  = 5'h0C;
  localparam logic [4:0] SUB_PEND = 5'h18;

  localparam logic [7:0] THRESH_OFF = 8'hFF;

  // a line may compete only if its priority value is below the threshold
  function automatic logic beats_thresh(input logic [7:0] prio, input logic [7:0] thr);
    return (thr == THRESH_OFF) || (prio < thr);
  endfunction

  // strict compare keeps the earlier (lower numbered) line on a tie
  function automatic logic prio_better(input logic [7:0] cand, input logic [8:0] best);
    return {1'b0, cand} < best;
  endfunction

endpackage

// File: rtl/intc_mask_bank.sv
module intc_mask_bank #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_all,
  input  logic         wr_mask,
  input  logic         wr_set,
  input  logic         wr_clr,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] line_i,
  output logic [W-1:0] mask_o,
  output logic [W-1:0] pend_o
);

  logic [W-1:0] mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '1;
    else if (clr_all) mask_q <= '1;
    else if (wr_mask) mask_q <= wdata;
    else if (wr_set)  mask_q <= mask_q | wdata;
    else if (wr_clr)  mask_q <= mask_q & ~wdata;
  end

  assign mask_o = mask_q;
  assign pend_o = line_i & ~mask_q;

  AST_SET_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set && !clr_all && !wr_mask |=> ((mask_o & $past(wdata)) == $past(wdata))); // R3
  AST_CLR_UNMASKS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr && !clr_all && !wr_mask && !wr_set |=> ((mask_o & $past(wdata)) == '0)); // R2
  AST_CLR_KEEPS_OTHERS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr && !clr_all && !wr_mask && !wr_set |=>
      ((mask_o & ~$past(wdata)) == ($past(mask_o) & ~$past(wdata)))); // R2
  AST_SOFT_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> (mask_o == '1)); // R10

endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter
  import intc_pkg::*;
#(
  parameter int NSRC  = 96,
  parameter int NUM_W = 7
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NSRC-1:0]       pend_i,
  input  logic [NSRC-1:0][7:0]  prio_i,
  input  logic [7:0]            thresh_i,
  output logic                  found_o,
  output logic [NUM_W-1:0]      num_o
);

  logic [8:0] best;

  always_comb begin
    found_o = 1'b0;
    num_o   = '0;
    best    = 9'h100;
    for (int i = 0; i < NSRC; i++) begin
      if (pend_i[i] && beats_thresh(prio_i[i], thresh_i) && prio_better(prio_i[i], best)) begin
        found_o = 1'b1;
        best    = {1'b0, prio_i[i]};
        num_o   = NUM_W'(i);
      end
    end
  end

  AST_WINNER_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    found_o |-> pend_i[num_o]); // R5
  AST_WINNER_PASSES_THRESH: assert property (@(posedge clk) disable iff (!rst_n)
    found_o |-> ((thresh_i == 8'hFF) || (prio_i[num_o] < thresh_i))); // R6

endmodule

// File: rtl/intc_softrst.sv
module intc_softrst #(
  parameter int CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy_o
);

  localparam int CW = $clog2(CYC + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    else if (start)          cnt_q <= CW'(CYC);
  end

  assign busy_o = (cnt_q != '0);

  AST_SRST_START: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy_o |=> busy_o); // R10
  AST_SRST_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CW'(1)) |=> !busy_o); // R10

endmodule

// File: rtl/intc_vec_top.sv
module intc_vec_top
  import intc_pkg::*;
#(
  parameter int NUM_SRC  = 96,
  parameter int REV_MAJ  = 2,
  parameter int REV_MIN  = 1,
  parameter int SRST_CYC = 4,
  parameter int ADDR_W   = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               bus_sel,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               irq_o
);

  localparam int BANK_W = 32;
  localparam int NBANK  = (NUM_SRC + BANK_W - 1) / BANK_W;
  localparam int NPAD   = NBANK * BANK_W;
  localparam int NUM_W  = 7;
  localparam int PIDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam int BIDX_W = ADDR_W - 5;

  // ---------------- events as named wires ----------------
  logic soft_clr;
  logic wr_en;
  logic ack_wr;
  logic srst_start;
  logic arb_found;
  logic [NUM_W-1:0] arb_num;

  assign wr_en      = bus_sel && bus_we && !soft_clr;
  assign ack_wr     = wr_en && (bus_addr == ADDR_W'(OFF_CTRL)) && bus_wdata[0];
  assign srst_start = wr_en && (bus_addr == ADDR_W'(OFF_SYSCFG)) && bus_wdata[1];

  // ---------------- address decode ----------------
  logic              bank_hit;
  logic [ADDR_W-1:0] bank_off;
  logic [BIDX_W-1:0] bank_idx;
  logic [4:0]        bank_sub;
  logic              prio_hit;
  logic [ADDR_W-1:0] prio_off;
  logic [PIDX_W-1:0] prio_idx;

  assign bank_off = bus_addr - ADDR_W'(OFF_BANK0);
  assign bank_idx = bank_off[ADDR_W-1:5];
  assign bank_sub = bank_off[4:0];
  assign bank_hit = (bus_addr >= ADDR_W'(OFF_BANK0)) &&
                    (bus_addr <  ADDR_W'(OFF_BANK0 + BANK_STRIDE * NBANK));

  assign prio_off = bus_addr - ADDR_W'(OFF_PRIO);
  assign prio_idx = PIDX_W'(prio_off >> 2);
  assign prio_hit = (bus_addr >= ADDR_W'(OFF_PRIO)) &&
                    (bus_addr <  ADDR_W'(OFF_PRIO + 4 * NUM_SRC)) &&
                    (bus_addr[1:0] == 2'b00);

  // ---------------- soft reset sequencer ----------------
  intc_softrst #(.CYC(SRST_CYC)) u_srst (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (srst_start),
    .busy_o (soft_clr)
  );

  // ---------------- mask banks ----------------
  logic [NPAD-1:0]               src_pad;
  logic [NBANK-1:0][BANK_W-1:0]  mask_b;
  logic [NBANK-1:0][BANK_W-1:0]  pend_b;
  logic [NPAD-1:0]               pend_flat;

  assign src_pad   = NPAD'(src_i);
  assign pend_flat = pend_b;

  for (genvar k = 0; k < NBANK; k++) begin : g_bank
    logic sel_k;
    assign sel_k = wr_en && bank_hit && (bank_idx == BIDX_W'(k));

    intc_mask_bank #(.W(BANK_W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_all (soft_clr),
      .wr_mask (sel_k && (bank_sub == SUB_MASK)),
      .wr_set  (sel_k && (bank_sub == SUB_SET)),
      .wr_clr  (sel_k && (bank_sub == SUB_CLR)),
      .wdata   (bus_wdata),
      .line_i  (src_pad[k*BANK_W +: BANK_W]),
      .mask_o  (mask_b[k]),
      .pend_o  (pend_b[k])
    );
  end

  // ---------------- priority, threshold, idle, config ----------------
  logic [NUM_SRC-1:0][7:0] prio_q;
  logic [7:0]              thresh_q;
  logic [1:0]              idle_q;
  logic                    autoidle_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  prio_q <= '0;
    else if (soft_clr)           prio_q <= '0;
    else if (wr_en && prio_hit)  prio_q[prio_idx] <= bus_wdata[7:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n || soft_clr) begin
      thresh_q   <= THRESH_OFF;
      idle_q     <= '0;
      autoidle_q <= 1'b0;
    end else if (wr_en) begin
      if (bus_addr == ADDR_W'(OFF_THRESH)) thresh_q <= bus_wdata[7:0];
      if (bus_addr == ADDR_W'(OFF_IDLE))   idle_q   <= bus_wdata[1:0];
      if ((bus_addr == ADDR_W'(OFF_SYSCFG)) && !bus_wdata[1]) autoidle_q <= bus_wdata[0];
    end
  end

  // ---------------- arbitration ----------------
  intc_arbiter #(.NSRC(NUM_SRC), .NUM_W(NUM_W)) u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .pend_i   (pend_flat[NUM_SRC-1:0]),
    .prio_i   (prio_q),
    .thresh_i (thresh_q),
    .found_o  (arb_found),
    .num_o    (arb_num)
  );

  // ---------------- active capture and acknowledge ----------------
  logic             busy_q;
  logic [NUM_W-1:0] act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      act_q  <= '0;
    end else if (soft_clr) begin
      busy_q <= 1'b0;
      act_q  <= '0;
    end else if (busy_q) begin
      if (ack_wr) begin
        busy_q <= 1'b0;
        act_q  <= '0;
      end
    end else if (arb_found) begin
      busy_q <= 1'b1;
      act_q  <= arb_num;
    end
  end

  assign irq_o = busy_q;

  // ---------------- read mux ----------------
  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(OFF_REV))    bus_rdata = {24'b0, 4'(REV_MAJ), 4'(REV_MIN)};
    if (bus_addr == ADDR_W'(OFF_SYSCFG)) bus_rdata = {30'b0, soft_clr, autoidle_q};
    if (bus_addr == ADDR_W'(OFF_STATUS)) bus_rdata = {31'b0, !soft_clr};
    if (bus_addr == ADDR_W'(OFF_ACTIVE)) bus_rdata = {{(32-NUM_W){1'b0}}, act_q};
    if (bus_addr == ADDR_W'(OFF_IDLE))   bus_rdata = {30'b0, idle_q};
    if (bus_addr == ADDR_W'(OFF_THRESH)) bus_rdata = {24'b0, thresh_q};
    if (prio_hit)                        bus_rdata = {24'b0, prio_q[prio_idx]};
    for (int k = 0; k < NBANK; k++) begin
      if (bank_hit && (bank_idx == BIDX_W'(k))) begin
        if (bank_sub == SUB_MASK) bus_rdata = mask_b[k];
        if (bank_sub == SUB_PEND) bus_rdata = pend_b[k];
      end
    end
  end

  // ---------------- assertions ----------------
  AST_ACTIVE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !ack_wr && !soft_clr |=> irq_o && (act_q == $past(act_q))); // R7
  AST_RAISE_ON_CAND: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_o && arb_found && !soft_clr |=> irq_o); // R7
  AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    ack_wr && irq_o |=> !irq_o && (act_q == '0)); // R8
  AST_NO_CAND_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_o && !arb_found |=> !irq_o); // R6
  AST_SRST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> !irq_o && (thresh_q == THRESH_OFF)); // R10

endmodule

// File: tb/tb_intc_vec_top.sv
module tb_intc_vec_top;

  localparam int NSRC = 96;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NSRC-1:0] src = '0;
  logic            bus_sel = 1'b0;
  logic            bus_we = 1'b0;
  logic [11:0]     bus_addr = '0;
  logic [31:0]     bus_wdata = '0;
  logic [31:0]     bus_rdata;
  logic            irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  intc_vec_top #(.NUM_SRC(NSRC)) dut (
    .clk(clk), .rst_n(rst_n), .src_i(src),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq)
  );

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t sb[$];

  // monitor: compares queued expectations away from the clock edge
  always @(negedge clk) begin
    #2;
    while (sb.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = sb.pop_front();
      act = it.is_irq ? {31'b0, irq} : bus_rdata;
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    sb.push_back('{1'b0, e, tag});
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
  endtask

  task automatic peek_irq(input logic e, input string tag);
    sb.push_back('{1'b1, {31'b0, e}, tag});
  endtask

  task automatic idle_chk_irq(input logic e, input string tag);
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
    peek_irq(e, tag);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // reset state
    rd(12'h000, 32'h21, "R1 revision");
    rd(12'h084, 32'hFFFF_FFFF, "R1 mask bank0");
    rd(12'h0C4, 32'hFFFF_FFFF, "R1 mask bank2");
    rd(12'h098, 32'h0, "R1 pending bank0");
    rd(12'h040, 32'h0, "R1 active");
    peek_irq(1'b0, "R1 irq low");
    rd(12'h068, 32'hFF, "R1 threshold");
    rd(12'h014, 32'h1, "R10 status after reset");

    // readback registers
    wr(12'h10C, 32'h0000_00A5);
    rd(12'h10C, 32'hA5, "R9 prio3");
    wr(12'h11C, 32'hFFFF_FF3C);
    rd(12'h11C, 32'h3C, "R9 prio7 upper bits zero");
    wr(12'h068, 32'h40);
    rd(12'h068, 32'h40, "R9 threshold");
    wr(12'h068, 32'hFF);
    wr(12'h050, 32'h3);
    rd(12'h050, 32'h3, "R9 idle");
    wr(12'h010, 32'h1);
    rd(12'h010, 32'h1, "R9 autoidle");

    // unmask / mask aliases
    wr(12'h088, 32'h30);
    rd(12'h084, 32'hFFFF_FFCF, "R2 unmask bits 4,5");
    wr(12'h088, 32'h0);
    rd(12'h084, 32'hFFFF_FFCF, "R2 zero write no effect");
    wr(12'h08C, 32'h10);
    rd(12'h084, 32'hFFFF_FFDF, "R3 mask bit 4");
    rd(12'h098, 32'h0, "R4 pending no lines");

    // pending view and first capture (lines 4,5,40; only 5 unmasked)
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = 12'h098;
    src[4] = 1'b1; src[5] = 1'b1; src[40] = 1'b1;
    sb.push_back('{1'b0, 32'h20, "R4 pending bank0"});
    rd(12'h0B8, 32'h0, "R4 pending bank1 masked");
    wr(12'h0A8, 32'h100);
    rd(12'h0B8, 32'h100, "R4 pending bank1 line 40");
    rd(12'h040, 32'd5, "R5 tie goes to lower number");
    peek_irq(1'b1, "R7 irq raised");
    src[5] = 1'b0;
    rd(12'h040, 32'd5, "R7 number held after line drop");
    peek_irq(1'b1, "R7 irq held");

    // acknowledge
    wr(12'h048, 32'h0);
    rd(12'h040, 32'd5, "R8 zero write no effect");
    peek_irq(1'b1, "R8 irq still high");
    wr(12'h048, 32'h1);
    rd(12'h040, 32'd0, "R8 active cleared");
    peek_irq(1'b0, "R8 irq dropped");
    rd(12'h040, 32'd40, "R8 reselect line 40");
    peek_irq(1'b1, "R8 irq again");

    // priority order: line 4 (3) beats line 40 (9)
    wr(12'h1A0, 32'h9);
    wr(12'h110, 32'h3);
    wr(12'h088, 32'h10);
    rd(12'h040, 32'd40, "R7 held while better line pends");
    wr(12'h048, 32'h1);
    rd(12'h040, 32'd0, "R8 cleared");
    rd(12'h040, 32'd4, "R5 smallest value wins");

    // threshold
    wr(12'h068, 32'h3);
    wr(12'h048, 32'h1);
    rd(12'h040, 32'd0, "R6 cleared");
    rd(12'h040, 32'd0, "R6 nothing beats threshold 3");
    peek_irq(1'b0, "R6 irq low");
    wr(12'h068, 32'h0A);
    rd(12'h040, 32'd0, "R6 threshold just written");
    rd(12'h040, 32'd4, "R6 line 4 passes threshold 10");

    // ack coincides with arrival of a better line
    wr(12'h088, 32'h4);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 12'h048; bus_wdata = 32'h1;
    src[2] = 1'b1;
    rd(12'h040, 32'd0, "R8 ack with new line");
    rd(12'h040, 32'd2, "R5 new best line 2 after ack");

    // soft reset while active
    wr(12'h010, 32'h2);
    rd(12'h014, 32'h0, "R10 status busy");
    wr(12'h068, 32'h11);
    rd(12'h010, 32'h2, "R10 request bit set");
    idle_chk_irq(1'b0, "R10 irq low during reset");
    rd(12'h014, 32'h1, "R10 status done");
    rd(12'h010, 32'h0, "R10 request self-cleared");
    rd(12'h068, 32'hFF, "R10 threshold default, write ignored");
    rd(12'h084, 32'hFFFF_FFFF, "R10 mask default");
    rd(12'h0A4, 32'hFFFF_FFFF, "R10 mask bank1 default");
    rd(12'h110, 32'h0, "R10 prio default");
    rd(12'h050, 32'h0, "R10 idle default");
    rd(12'h040, 32'h0, "R10 active default");
    peek_irq(1'b0, "R10 irq low after reset");

    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
    #5;
    done = 1;
    summary();
    $finish;
  end

endmodule